// File: doc/BRIEF.md
# Tile Write-Back Signature Filter

This block sits between the on-chip tile buffer of a tile-based renderer and the path that writes finished tiles to memory. Each finished tile arrives as a burst of color words. While the burst streams in, the block builds a CRC-32 signature over the words and keeps a copy of the tile. On the final beat it looks up the signature stored for that tile position in a small on-chip table. If the stored entry is valid and holds the same signature, the tile is dropped and a skip counter advances. In every other case the tile is replayed on a handshaked memory-write port and the table entry takes the new signature.

Only tiles that leave through this path refresh the table. When the image is written by some other path (for example a shader store), or when a state change discards what is known about the image, the controlling logic pulses a flush input that invalidates every entry before the next render pass. For multi-sampled images a mode input turns the filter off, so every tile is written.

Top module: `tile_wb_elim`

## Requirements
- R1: A tile is exactly 16 beats of 32-bit words, accepted when `in_valid` and `in_ready` are both high, with `in_last` high on the 16th beat. `in_ready` is high whenever no forwarded tile is waiting to drain.
- R2: A tile whose table entry is invalid (after reset or after a flush) is always forwarded, and its entry then becomes valid with the tile's signature, so an identical repeat is skipped.
- R3: The signature is a CRC-32 (polynomial 0x04C11DB7, initial value 0xFFFFFFFF, each word fed MSB first, beat 0 first, no reflection and no final inversion). A tile whose signature differs from a valid stored one is forwarded and the stored value is replaced, so changing one bit of one word causes a write.
- R4: A tile whose signature matches the valid stored one for the same tile index produces no output beats. `in_ready` stays high and `skip_count` has risen by one in the cycle after the last input beat.
- R5: A forwarded tile drives `out_valid` in the cycle after its last input beat and then delivers its 16 words in input order, with `out_tile` equal to the tile index and `out_last` high only on the 16th word.
- R6: While `out_valid` is high and `out_ready` is low, `out_data`, `out_tile` and `out_last` hold steady and `in_ready` stays low.
- R7: A one-cycle `sig_flush` pulse invalidates all 64 entries. If the pulse falls in the same cycle as a tile's last beat, that tile is forwarded and its entry stays invalid, so its next arrival is forwarded again.
- R8: With `multisample` high on the last beat, the tile is always forwarded and its table entry is left unchanged.
- R9: `skip_count` is 16 bits wide, is zero after reset and rises by exactly one for each dropped tile and for nothing else.
- R10: During and right after a synchronous reset `out_valid` is low, `in_ready` is high, `skip_count` is zero and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Tile beat present |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 32 | Color word of the current beat |
| in_tile | input | 6 | Tile index, sampled on the last beat |
| in_last | input | 1 | Marks the 16th beat of a tile |
| multisample | input | 1 | Disables filtering, sampled on the last beat |
| sig_flush | input | 1 | Invalidate every stored signature |
| out_valid | output | 1 | Memory-write beat present |
| out_ready | input | 1 | Memory path takes the beat |
| out_data | output | 32 | Color word being written |
| out_tile | output | 6 | Tile index of the write |
| out_last | output | 1 | Final word of the tile write |
| skip_count | output | 16 | Number of dropped tiles |

## Verification
The write-or-drop decision is made on the clock edge that takes the last input beat, so both `out_valid` and the new `skip_count` are due one cycle later. The bench reads them at the falling edge right after that beat. Forwarded words then follow at one word per cycle while `out_ready` is high. Each one is compared at the falling edge before the rising edge that consumes it, and `in_ready` is checked one cycle after the final word. In stall tests the bench holds `out_ready` low for a set number of cycles and checks that the first word and the low `in_ready` stay unchanged on each of those cycles.

// File: rtl/tile_wb_pkg.sv
package tile_wb_pkg;

    localparam int WORD_W     = 32;
    localparam int TILE_BEATS = 16;
    localparam int TILE_IDX_W = 6;
    localparam int SKIP_W     = 16;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [0:0] {
        ST_GATHER = 1'b0,
        ST_DRAIN  = 1'b1
    } wb_state_e;

    // Fold one 32-bit word into the running CRC, most significant bit first.
    function automatic logic [31:0] crc32_fold(input logic [31:0] crc_in,
                                               input logic [31:0] word);
        logic [31:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ word[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/tile_sig_crc.sv
module tile_sig_crc
    import tile_wb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        beat_en,
    input  logic        beat_first,
    input  logic [31:0] beat_word,
    output logic [31:0] sig_next
);
    logic [31:0] crc_q;
    logic [31:0] crc_base;

    assign crc_base = beat_first ? CRC_SEED : crc_q;
    assign sig_next = crc32_fold(crc_base, beat_word);

    always_ff @(posedge clk) begin
        if (rst)          crc_q <= CRC_SEED;
        else if (beat_en) crc_q <= sig_next;
    end
endmodule

// File: rtl/tile_sig_table.sv
module tile_sig_table #(
    parameter int ENTRIES = 64,
    parameter int SIG_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [SIG_W-1:0] rd_sig,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SIG_W-1:0] wr_sig
);
    logic [ENTRIES-1:0] valid_q;
    logic [SIG_W-1:0]   sig_q [ENTRIES];

    assign rd_valid = valid_q[rd_idx];
    assign rd_sig   = sig_q[rd_idx];

    // Flush outranks a same-cycle update: the entry stays invalid.
    always_ff @(posedge clk) begin
        if (rst || flush)  valid_q <= '0;
        else if (wr_en)    valid_q[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) sig_q[wr_idx] <= wr_sig;
    end

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_q == '0));

    assert_write_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/tile_beat_buf.sv
module tile_beat_buf #(
    parameter int DEPTH   = 16,
    parameter int WIDTH   = 32,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/tile_wb_elim.sv
module tile_wb_elim
    import tile_wb_pkg::*;
#(
    parameter int BEATS   = TILE_BEATS,
    parameter int IDX_W   = TILE_IDX_W,
    parameter int DATA_W  = WORD_W,
    parameter int CNT_W   = SKIP_W,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int BEAT_W  = $clog2(BEATS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [IDX_W-1:0]  in_tile,
    input  logic              in_last,
    input  logic              multisample,
    input  logic              sig_flush,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [IDX_W-1:0]  out_tile,
    output logic              out_last,
    output logic [CNT_W-1:0]  skip_count
);
    wb_state_e         state_q;
    logic [BEAT_W-1:0] in_cnt_q;
    logic [BEAT_W-1:0] out_cnt_q;
    logic [IDX_W-1:0]  tile_q;
    logic [CNT_W-1:0]  skip_q;

    logic              accept, last_acc, out_fire;
    logic [31:0]       sig_now;
    logic              tbl_valid;
    logic [31:0]       tbl_sig;
    logic              hit;
    logic              tbl_wr;

    assign in_ready = (state_q == ST_GATHER);
    assign accept   = in_valid && in_ready;
    assign last_acc = accept && in_last;

    tile_sig_crc u_crc (
        .clk        (clk),
        .rst        (rst),
        .beat_en    (accept),
        .beat_first (in_cnt_q == '0),
        .beat_word  (in_data),
        .sig_next   (sig_now)
    );

    tile_sig_table #(.ENTRIES(ENTRIES), .SIG_W(32)) u_table (
        .clk      (clk),
        .rst      (rst),
        .flush    (sig_flush),
        .rd_idx   (in_tile),
        .rd_valid (tbl_valid),
        .rd_sig   (tbl_sig),
        .wr_en    (tbl_wr),
        .wr_idx   (in_tile),
        .wr_sig   (sig_now)
    );

    tile_beat_buf #(.DEPTH(BEATS), .WIDTH(DATA_W)) u_buf (
        .clk     (clk),
        .wr_en   (accept),
        .wr_addr (in_cnt_q),
        .wr_data (in_data),
        .rd_addr (out_cnt_q),
        .rd_data (out_data)
    );

    // A same-cycle flush makes the lookup count as invalid.
    assign hit    = tbl_valid && !sig_flush && !multisample && (tbl_sig == sig_now);
    assign tbl_wr = last_acc && !hit && !multisample;

    assign out_valid = (state_q == ST_DRAIN);
    assign out_tile  = tile_q;
    assign out_last  = out_valid && (out_cnt_q == BEAT_W'(BEATS - 1));
    assign out_fire  = out_valid && out_ready;
    assign skip_count = skip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_GATHER;
            in_cnt_q  <= '0;
            out_cnt_q <= '0;
            tile_q    <= '0;
            skip_q    <= '0;
        end else begin
            if (accept) in_cnt_q <= last_acc ? '0 : in_cnt_q + 1'b1;
            unique case (state_q)
                ST_GATHER: begin
                    if (last_acc) begin
                        if (hit) begin
                            skip_q <= skip_q + 1'b1;
                        end else begin
                            state_q   <= ST_DRAIN;
                            tile_q    <= in_tile;
                            out_cnt_q <= '0;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (out_fire) begin
                        out_cnt_q <= out_cnt_q + 1'b1;
                        if (out_last) state_q <= ST_GATHER;
                    end
                end
                default: state_q <= ST_GATHER;
            endcase
        end
    end

    assert_last_align_R1: assert property (@(posedge clk) disable iff (rst)
        (accept && in_last) |-> (in_cnt_q == BEAT_W'(BEATS - 1)));

    assert_skip_or_write_R4: assert property (@(posedge clk) disable iff (rst)
        last_acc |=> (out_valid || (skip_count == $past(skip_count) + 1'b1)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                       $stable(out_tile) && $stable(out_last)));

    assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (last_acc && multisample) |=> out_valid);

    assert_skip_step_R9: assert property (@(posedge clk) disable iff (rst)
        (skip_count == $past(skip_count)) || (skip_count == $past(skip_count) + 1'b1));
endmodule

// File: tb/tile_wb_elim_test.sv
module tile_wb_elim_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic [5:0]  in_tile = '0;
    logic        in_last = 1'b0;
    logic        multisample = 1'b0;
    logic        sig_flush = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [5:0]  out_tile;
    logic        out_last;
    logic [15:0] skip_count;

    int checks = 0;
    int errors = 0;
    int exp_skip = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    tile_wb_elim uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_tile(in_tile), .in_last(in_last),
        .multisample(multisample), .sig_flush(sig_flush),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_tile(out_tile), .out_last(out_last), .skip_count(skip_count)
    );

    // Fields: tile[15:10] seed[9:6] multisample[5] flush_before[4] expect_write[3]
    localparam int NVEC = 12;
    localparam logic [15:0] VEC [NVEC] = '{
        {6'd5,  4'd1, 1'b0, 1'b0, 1'b1, 3'b0},  // R2 first visit
        {6'd5,  4'd1, 1'b0, 1'b0, 1'b0, 3'b0},  // R4 repeat
        {6'd5,  4'd2, 1'b0, 1'b0, 1'b1, 3'b0},  // R3 new content
        {6'd5,  4'd2, 1'b0, 1'b0, 1'b0, 3'b0},  // R4
        {6'd9,  4'd2, 1'b0, 1'b0, 1'b1, 3'b0},  // R2 other index
        {6'd5,  4'd2, 1'b0, 1'b1, 1'b1, 3'b0},  // R7 flushed
        {6'd5,  4'd2, 1'b0, 1'b0, 1'b0, 3'b0},  // R2 refilled
        {6'd63, 4'd3, 1'b0, 1'b0, 1'b1, 3'b0},  // R2 top index
        {6'd63, 4'd3, 1'b1, 1'b0, 1'b1, 3'b0},  // R8 bypass
        {6'd63, 4'd3, 1'b0, 1'b0, 1'b0, 3'b0},  // R8 entry untouched
        {6'd0,  4'd4, 1'b0, 1'b0, 1'b1, 3'b0},  // R2 index zero
        {6'd0,  4'd4, 1'b0, 1'b0, 1'b0, 3'b0}   // R4
    };

    function automatic logic [31:0] word_of(input int seed, input int k, input logic [31:0] tweak);
        logic [31:0] w;
        w = (32'(seed) * 32'h9E37_79B9) ^ (32'(k) * 32'h0101_0101) ^ 32'h5A5A_0000;
        if (k == 15) w = w ^ tweak;
        return w;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_flush();
        @(negedge clk) sig_flush = 1'b1;
        @(negedge clk) sig_flush = 1'b0;
    endtask

    task automatic run_tile(input int tile, input int seed, input logic [31:0] tweak,
                            input logic ms, input logic flush_last, input logic exp_write,
                            input int stall, input string req);
        logic bad;
        out_ready = (stall == 0);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            in_valid    = 1'b1;
            in_data     = word_of(seed, k, tweak);
            in_tile     = 6'(tile);
            in_last     = (k == 15);
            multisample = ms;
            sig_flush   = flush_last && (k == 15);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; multisample = 1'b0; sig_flush = 1'b0;
        if (!exp_write) exp_skip++;
        check(out_valid == exp_write, req, 32'(out_valid), 32'(exp_write));
        check(skip_count == 16'(exp_skip), "R9 skip_count", 32'(skip_count), 32'(exp_skip));
        if (exp_write) begin
            for (int s = 0; s < stall; s++) begin
                check(out_valid && !in_ready && out_data == word_of(seed, 0, tweak),
                      "R6 stall hold", out_data, word_of(seed, 0, tweak));
                @(negedge clk);
            end
            out_ready = 1'b1;
            bad = 1'b0;
            for (int k = 0; k < 16; k++) begin
                if (!out_valid || out_data != word_of(seed, k, tweak) ||
                    out_tile != 6'(tile) || out_last != (k == 15) || in_ready) bad = 1'b1;
                if (k < 15) @(negedge clk);
            end
            check(!bad, "R5 forwarded beats", 32'(bad), 32'd0);
            @(negedge clk);
        end
        check(in_ready && !out_valid, "R1 ready after tile", 32'(in_ready), 32'd1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!out_valid && in_ready && skip_count == 0, "R10 in reset",
              {out_valid, in_ready, 14'd0, skip_count}, 32'h4000_0000);
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready && skip_count == 0, "R10 after reset",
              {out_valid, in_ready, 14'd0, skip_count}, 32'h4000_0000);

        foreach (VEC[i]) begin
            if (VEC[i][4]) pulse_flush();
            run_tile(int'(VEC[i][15:10]), int'(VEC[i][9:6]), 32'd0, VEC[i][5], 1'b0,
                     VEC[i][3], 0, $sformatf("R2/R4 vector %0d", i));
        end

        // R3: one bit flipped in the last word forces a write, then matches
        run_tile(0, 4, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 0, "R3 single-bit change");
        run_tile(0, 4, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 0, "R3 replaced value");

        // R7: flush on the last beat wins over the update
        run_tile(9, 2, 32'd0, 1'b0, 1'b1, 1'b1, 0, "R7 flush with last beat");
        run_tile(9, 2, 32'd0, 1'b0, 1'b0, 1'b1, 0, "R7 entry left invalid");
        run_tile(9, 2, 32'd0, 1'b0, 1'b0, 1'b0, 0, "R7 refilled");

        // R7: flush reaches every index
        pulse_flush();
        run_tile(63, 3, 32'd0, 1'b0, 1'b0, 1'b1, 0, "R7 flush index 63");
        run_tile(5, 2, 32'd0, 1'b0, 1'b0, 1'b1, 0, "R7 flush index 5");

        // R6: back-pressure on the write port
        run_tile(20, 7, 32'd0, 1'b0, 1'b0, 1'b1, 3, "R6 stalled write");
        run_tile(20, 7, 32'd0, 1'b0, 1'b0, 1'b0, 0, "R6 stored after stall");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule